// File: doc/BRIEF.md
# Gain-Compensating Sample Word Aligner

This block sits between a dual-converter input stage and the input FIFO of a 24-bit signal processor. Each valid cycle it takes the 18-bit signed sample of the channel now in use, together with a code for the preamplifier gain that channel is running at. It then writes a 24-bit signed word whose level does not depend on that gain. A sample taken at high gain is left where it is. A sample taken at lower gain is shifted left by one bit for every 6 dB of gain it lacks against the 30 dB top step. A handover between channels or gain steps therefore leaves no step in the output. In extended mode the result spans 23 significant bits, and bit 23 copies the sign.

With extension off, the block is a plain input aligner. The sample goes either to the low 18 bits with the sign copied above, or to the high 18 bits with zeros below. The gain code and the mode inputs are sampled in the same cycle as the sample. A later change on them cannot alter a word that is already captured.

Top module: `gain_word_aligner`

## Requirements
- R1: While reset is asserted and after it is released, `outValid` is 0 and `outWord` is 0 until the first valid sample.
- R2: A sample presented with `inValid` high gives `outValid` high on the next clock edge, with `outWord` holding that sample's aligned result. Back-to-back valid cycles give back-to-back results.
- R3: A cycle without `inValid` gives `outValid` low on the next edge, and `outWord` keeps its previous value.
- R4: In extended mode (`extendEn`=1), the gain code selects the left shift. Code 0 (30 dB) shifts by 0, code 1 (24 dB) by 1, code 2 (18 dB) by 2, code 3 (12 dB) by 3, and code 4 (0 dB) by 5.
- R5: In extended mode, the unused gain codes 5, 6 and 7 are treated as 0 dB, with a shift of 5.
- R6: An extended-mode word is the shifted sample sign-extended to 24 bits. Bit 23 equals bit 22, and the low bits vacated by the shift are zero. The full-scale extremes -2^17 and 2^17-1 are scaled without overflow.
- R7: In bypass mode with `alignUpper`=0, bits 17:0 carry the sample and bits 23:18 copy its sign bit.
- R8: In bypass mode with `alignUpper`=1, bits 23:6 carry the sample and bits 5:0 are zero.
- R9: `extendEn` takes priority over `alignUpper`, and the gain code has no effect in bypass mode.
- R10: The gain code and mode inputs are captured only on the valid cycle. Changing them in cycles without `inValid` does not alter the held `outWord`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Sample strobe |
| inSample | input | 18 | Signed sample of the channel in use |
| gainCode | input | 3 | Preamplifier gain step of that channel (0 = 30 dB … 4 = 0 dB) |
| extendEn | input | 1 | 1 = gain-compensated extended range, 0 = bypass alignment |
| alignUpper | input | 1 | Bypass alignment: 1 = upper 18 bits, 0 = lower 18 bits |
| outValid | output | 1 | Result strobe, one cycle after `inValid` |
| outWord | output | 24 | Aligned signed word for the FIFO |

## Verification
Every result is due exactly one clock edge after its valid cycle, because only one register lies between the inputs and the outputs. The bench drives inputs on the falling edge and reads the outputs on the following falling edge, half a period after the capturing edge. In the streaming scenario, the next sample goes out in the same falling-edge slot in which the previous result is checked. For hold behaviour, the bench changes the sample, gain and mode with `inValid` low and reads `outWord` over two more falling edges, where it must be unchanged.

// File: rtl/gain_word_aligner_pkg.sv
package gain_word_aligner_pkg;

  // Widths of the input sample and the FIFO word.
  parameter int SAMPLE_W = 18;
  parameter int WORD_W   = 24;

  // Gain ladder: top step in dB, dB per bit of shift, number of regular steps.
  parameter int TOP_GAIN_DB  = 30;
  parameter int STEP_DB      = 6;
  parameter int LADDER_STEPS = 4;   // codes 0..3 map to one bit each
  parameter int GAIN_W       = 3;

  // Derived quantities.
  localparam int MAX_SHIFT = TOP_GAIN_DB / STEP_DB;          // 0 dB step
  localparam int EXT_W     = SAMPLE_W + MAX_SHIFT;           // significant bits
  localparam int SHIFT_W   = $clog2(MAX_SHIFT + 1);
  localparam int PAD_LO_W  = WORD_W - SAMPLE_W;              // pad for upper align
  localparam int SIGN_X_W  = WORD_W - SAMPLE_W;              // sign copies, lower align

  typedef logic signed [SAMPLE_W-1:0] sample_t;
  typedef logic signed [WORD_W-1:0]   word_t;
  typedef logic [GAIN_W-1:0]          gain_code_t;
  typedef logic [SHIFT_W-1:0]         shift_t;

  typedef enum logic [1:0] {
    ALIGN_LOWER  = 2'd0,
    ALIGN_UPPER  = 2'd1,
    ALIGN_EXTEND = 2'd2
  } align_mode_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic   load;
    logic   selExtend;
    logic   selUpper;
    logic   selLower;
    shift_t shiftAmt;
  } align_strobe_t;

endpackage

// File: rtl/gain_word_aligner_ctrl.sv
module gain_word_aligner_ctrl
  import gain_word_aligner_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  gain_code_t    gainCode,
  input  logic          extendEn,
  input  logic          alignUpper,
  output align_strobe_t strobe
);

  align_mode_e modeSel;
  shift_t      gainShift;

  // Mode priority: extension first, then the bypass alignment choice.
  always_comb begin
    if (extendEn)        modeSel = ALIGN_EXTEND;
    else if (alignUpper) modeSel = ALIGN_UPPER;
    else                 modeSel = ALIGN_LOWER;
  end

  // Gain step to shift: regular steps shift one bit each; the bottom step
  // and any unused code take the full shift.
  always_comb begin
    if (32'(gainCode) < LADDER_STEPS) gainShift = shift_t'(gainCode);
    else                              gainShift = shift_t'(MAX_SHIFT);
  end

  always_comb begin
    strobe.load      = inValid;
    strobe.selExtend = (modeSel == ALIGN_EXTEND);
    strobe.selUpper  = (modeSel == ALIGN_UPPER);
    strobe.selLower  = (modeSel == ALIGN_LOWER);
    strobe.shiftAmt  = (modeSel == ALIGN_EXTEND) ? gainShift : '0;
  end

  // R9: exactly one alignment path is chosen in every cycle.
  always_comb begin
    assert_one_mode_R9: assert ($onehot({strobe.selExtend, strobe.selUpper, strobe.selLower}))
      else $error("alignment selects not one-hot");
  end

  // R4/R5: the shift never exceeds the bottom-of-ladder value.
  assert_shift_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    32'(strobe.shiftAmt) <= MAX_SHIFT)
    else $error("shift out of range");

  // R9: bypass modes never carry a shift.
  assert_bypass_noshift_R9: assert property (@(posedge clk) disable iff (!rstN)
    !extendEn |-> (strobe.shiftAmt == '0))
    else $error("shift in bypass");

endmodule

// File: rtl/gain_word_aligner_dp.sv
module gain_word_aligner_dp
  import gain_word_aligner_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  sample_t       inSample,
  input  align_strobe_t strobe,
  output logic          outValid,
  output word_t         outWord
);

  word_t sampleWide;
  word_t upperWord;
  word_t shiftCand [MAX_SHIFT+1];
  word_t extWord;
  word_t nextWord;

  // Sign extension to the full word (lower alignment form).
  assign sampleWide = {{SIGN_X_W{inSample[SAMPLE_W-1]}}, inSample};

  // Upper alignment: sample at the top, zeros below.
  assign upperWord = {inSample, {PAD_LO_W{1'b0}}};

  // One candidate per legal shift.
  for (genvar s = 0; s <= MAX_SHIFT; s++) begin : g_shift
    assign shiftCand[s] = word_t'(sampleWide <<< s);
  end

  always_comb begin
    extWord = shiftCand[0];
    for (int k = 1; k <= MAX_SHIFT; k++) begin
      if (32'(strobe.shiftAmt) == k) extWord = shiftCand[k];
    end
  end

  always_comb begin
    unique case (1'b1)
      strobe.selExtend: nextWord = extWord;
      strobe.selUpper:  nextWord = upperWord;
      default:          nextWord = sampleWide;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outWord  <= '0;
    end else begin
      outValid <= strobe.load;
      if (strobe.load) outWord <= nextWord;
    end
  end

  // R2: a valid input yields a result on the next edge.
  assert_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> outValid)
    else $error("missing result strobe");

  // R3: no input, no result, word held.
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> (!outValid && $stable(outWord)))
    else $error("word changed without input");

  // R6: extended word sign-extends its 23-bit field.
  assert_ext_sign_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.selExtend) |=> (outWord[WORD_W-1] == outWord[EXT_W-1]))
    else $error("extended field not sign extended");

  // R6: vacated low bits are zero.
  assert_ext_lowzero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.selExtend) |=>
      ((outWord & ((word_t'(1) << $past(strobe.shiftAmt)) - word_t'(1))) == '0))
    else $error("low bits not cleared");

  // R8: upper alignment leaves the pad bits zero.
  assert_upper_pad_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.selUpper) |=> (outWord[PAD_LO_W-1:0] == '0))
    else $error("upper pad not zero");

  // R7: lower alignment copies the sign over the top bits.
  assert_lower_sign_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.selLower) |=>
      (outWord[WORD_W-1:SAMPLE_W] == {SIGN_X_W{outWord[SAMPLE_W-1]}}))
    else $error("lower sign copy wrong");

endmodule

// File: rtl/gain_word_aligner.sv
module gain_word_aligner
  import gain_word_aligner_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic signed [17:0]       inSample,
  input  logic [2:0]               gainCode,
  input  logic                     extendEn,
  input  logic                     alignUpper,
  output logic                     outValid,
  output logic signed [23:0]       outWord
);

  align_strobe_t strobe;

  gain_word_aligner_ctrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .gainCode   (gainCode),
    .extendEn   (extendEn),
    .alignUpper (alignUpper),
    .strobe     (strobe)
  );

  gain_word_aligner_dp i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inSample (inSample),
    .strobe   (strobe),
    .outValid (outValid),
    .outWord  (outWord)
  );

  // R1: reset clears the outputs on the following edge.
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (!outValid && (outWord == '0)))
    else $error("reset did not clear outputs");

endmodule

// File: tb/test_gain_word_aligner.sv
module test_gain_word_aligner;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic               clk = 1'b0;
  logic               rstN;
  logic               inValid;
  logic signed [17:0] inSample;
  logic [2:0]         gainCode;
  logic               extendEn;
  logic               alignUpper;
  logic               outValid;
  logic signed [23:0] outWord;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gain_word_aligner i_gain_word_aligner (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .inSample   (inSample),
    .gainCode   (gainCode),
    .extendEn   (extendEn),
    .alignUpper (alignUpper),
    .outValid   (outValid),
    .outWord    (outWord)
  );

  // Expected word from the requirements.
  function automatic logic [23:0] expWord(logic signed [17:0] s, logic [2:0] code,
                                          logic ext, logic up);
    longint v = s;
    int sh;
    case (code)
      3'd0: sh = 0;
      3'd1: sh = 1;
      3'd2: sh = 2;
      3'd3: sh = 3;
      default: sh = 5;
    endcase
    if (ext)     v = v * (longint'(1) << sh);
    else if (up) v = v * 64;
    return v[23:0];
  endfunction

  task automatic check(string req, logic [23:0] got, logic [23:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drive(logic v, logic signed [17:0] s, logic [2:0] c, logic e, logic u);
    inValid = v; inSample = s; gainCode = c; extendEn = e; alignUpper = u;
  endtask

  // One sample, result checked one edge later.
  task automatic sendOne(string req, logic signed [17:0] s, logic [2:0] c, logic e, logic u);
    @(negedge clk);
    drive(1'b1, s, c, e, u);
    @(negedge clk);
    check(req, 24'(outValid), 24'd1);
    check(req, outWord, expWord(s, c, e, u));
    inValid = 1'b0;
  endtask

  task automatic testReset();
    drive(1'b0, '0, '0, 1'b0, 1'b0);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", 24'(outValid), 24'd0);
    check("R1", outWord, 24'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", 24'(outValid), 24'd0);
    check("R1", outWord, 24'd0);
  endtask

  task automatic testGainLadder();
    logic signed [17:0] pats [4] = '{18'sd1, -18'sd1, 18'sd131071, -18'sd131072};
    for (int c = 0; c <= 4; c++) begin
      foreach (pats[p]) sendOne("R4", pats[p], 3'(c), 1'b1, 1'b0);
    end
    sendOne("R6", 18'sd131071, 3'd4, 1'b1, 1'b0);   // 0x3FFFE0
    check("R6", outWord, 24'h3FFFE0);
    sendOne("R6", -18'sd131072, 3'd4, 1'b1, 1'b0);  // 0xC00000
    check("R6", outWord, 24'hC00000);
  endtask

  task automatic testReservedCodes();
    for (int c = 5; c <= 7; c++) begin
      sendOne("R5", 18'sd12345, 3'(c), 1'b1, 1'b0);
      check("R5", outWord, 24'(12345 * 32));
    end
  endtask

  task automatic testBypass();
    sendOne("R7", -18'sd5, 3'd0, 1'b0, 1'b0);
    check("R7", outWord, 24'hFFFFFB);
    sendOne("R7", 18'sd77777, 3'd4, 1'b0, 1'b0);    // gain code ignored
    check("R9", outWord, 24'(77777));
    sendOne("R8", -18'sd1, 3'd2, 1'b0, 1'b1);
    check("R8", outWord, 24'hFFFFC0);
    sendOne("R8", 18'sd131071, 3'd4, 1'b0, 1'b1);
    check("R8", outWord, 24'h7FFFC0);
    sendOne("R9", 18'sd3, 3'd1, 1'b1, 1'b1);        // extension wins
    check("R9", outWord, 24'd6);
  endtask

  task automatic testHold();
    logic [23:0] held;
    sendOne("R10", 18'sd1000, 3'd2, 1'b1, 1'b0);
    held = outWord;
    drive(1'b0, -18'sd7, 3'd4, 1'b0, 1'b1);
    @(negedge clk);
    check("R3", 24'(outValid), 24'd0);
    check("R10", outWord, held);
    gainCode = 3'd0; extendEn = 1'b1;
    @(negedge clk);
    check("R10", outWord, held);
    check("R3", 24'(outValid), 24'd0);
  endtask

  task automatic testStream();
    logic signed [17:0] s;
    logic [2:0] c, pc;
    logic signed [17:0] ps;
    @(negedge clk);
    ps = 18'sd100; pc = 3'd0;
    drive(1'b1, ps, pc, 1'b1, 1'b0);
    for (int i = 1; i < 12; i++) begin
      @(negedge clk);
      check("R2", 24'(outValid), 24'd1);
      check("R2", outWord, expWord(ps, pc, 1'b1, 1'b0));
      s = 18'(i * 9173 - 50000);
      c = 3'(i % 8);
      drive(1'b1, s, c, 1'b1, 1'b0);
      ps = s; pc = c;
    end
    @(negedge clk);
    check("R2", outWord, expWord(ps, pc, 1'b1, 1'b0));
    inValid = 1'b0;
    @(negedge clk);
    check("R3", 24'(outValid), 24'd0);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    testReset();
    testGainLadder();
    testReservedCodes();
    testBypass();
    testHold();
    testStream();
    finish();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish();
  end

endmodule